// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block holds a core's executed stores between the execution stage and the level-one data cache. Writing a store into the queue does not make it visible anywhere else. Each entry waits until its store has retired. After that it may write to the cache, and entries always leave strictly oldest-first through a valid/ready port. This gives total-store-order behaviour: stores never pass each other, but a later load may pass an older queued store.

Loads present a word address and a byte mask and get one of three answers in the same cycle. If a queued store matches, the load takes that store's data. If the load must wait, it stalls. Otherwise it reads the cache. A full-fence request holds every load until the queue has fully drained. A pipeline flush squashes the unretired tail of the queue and keeps the retired entries.

Top module: `tso_stq`

## Requirements
- R1: A store offered with `st_valid` is written as the youngest entry when the queue is not full and `flush` is low. `st_full` is high exactly when DEPTH entries are held. A store offered while full or during a flush is not accepted.
- R2: Each cycle with `rt_valid` high marks the oldest not-yet-retired entry as retired, so entries retire in program order. A `rt_valid` pulse while no unretired entry exists has no effect.
- R3: `c_valid` is high only while the oldest entry is retired. `c_addr`, `c_data` and `c_mask` then show that entry, and entries reach the cache in the order they were accepted.
- R4: The head entry leaves only in a cycle where `c_valid` and `c_ready` are both high. While `c_ready` is low, the cache port outputs hold steady.
- R5: A load (`ld_valid` high) matches a queued entry with the same address whose byte mask overlaps the load mask. The youngest match is used. If that match covers every load byte, `ld_res` = 1 (forward) and `ld_data` is that entry's data word.
- R6: A load with no matching entry gives `ld_res` = 0 (read the cache), even while other stores are queued. `ld_res` is 0 whenever `ld_valid` is low.
- R7: If the youngest match leaves some load byte uncovered, `ld_res` = 2 (stall).
- R8: While `fence_req` is high and the queue holds any entry, retired or not, every load gets `ld_res` = 2. Once the queue is empty, loads resolve normally. With `fence_req` low, loads are not held back by queued stores.
- R9: A cycle with `flush` high removes every unretired entry. Retired entries stay and still commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Executed store offered |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_mask | input | DW/8 | Store byte enables |
| st_full | output | 1 | Queue holds DEPTH entries |
| rt_valid | input | 1 | Retire the oldest unretired store |
| flush | input | 1 | Squash all unretired entries |
| fence_req | input | 1 | Full fence: hold loads until queue is empty |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_mask | input | DW/8 | Load byte enables |
| ld_res | output | 2 | 0 cache, 1 forward, 2 stall |
| ld_data | output | DW | Forwarded data word |
| c_valid | output | 1 | Head entry ready to write the cache |
| c_addr | output | AW | Head address |
| c_data | output | DW | Head data |
| c_mask | output | DW/8 | Head byte enables |
| c_ready | input | 1 | Cache accepts the head entry |

## Verification
The hardest state to reach is a queue that is both wrapped around and mixed: retired entries sit at the head, unretired ones sit behind them, and a flush or a full fence arrives at that moment. The stimulus fills the small queue to capacity and retires only part of it while back-pressuring the cache port, then flushes. Loads probe which entries survived. A streaming sweep then pushes, retires and commits at once under an irregular ready pattern, so the pointers wrap several times while the commit order is checked against the arithmetic sequence of pushed addresses.

// File: rtl/tsq_pkg.sv
`timescale 1ns/1ps
package tsq_pkg;
  typedef enum logic [1:0] {
    LD_CACHE = 2'd0,
    LD_FWD   = 2'd1,
    LD_STALL = 2'd2
  } ld_res_e;
endpackage

// File: rtl/tsq_ctrl.sv
`timescale 1ns/1ps
// Occupancy, retirement boundary and head pointer of the queue.
module tsq_ctrl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic          rt_valid,
  input  logic          flush,
  input  logic          c_ready,
  output logic          push,
  output logic          st_full,
  output logic          c_valid,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] ret_cnt
);
  logic          pop, ret;
  logic [CW-1:0] occ_n, ret_n;
  logic [PW-1:0] head_n;

  always_comb begin
    st_full = (occ == CW'(DEPTH));
    push    = st_valid && !st_full && !flush;
    c_valid = (ret_cnt != '0);
    pop     = c_valid && c_ready;
    ret     = rt_valid && (ret_cnt < occ);
    ret_n   = ret_cnt + CW'(ret) - CW'(pop);
    occ_n   = flush ? ret_n : (occ + CW'(push) - CW'(pop));
    head_n  = head + PW'(1);
    tail    = head + occ[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      occ     <= '0;
      ret_cnt <= '0;
    end else begin
      if (pop) head <= head_n;
      if (push || pop || flush) occ <= occ_n;
      if (ret || pop) ret_cnt <= ret_n;
    end
  end
endmodule

// File: rtl/tsq_store.sv
`timescale 1ns/1ps
// Entry storage: written at the tail, read at the head and in parallel by the lookup.
module tsq_store #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int MW = DW / 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [PW-1:0]             wr_idx,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic [MW-1:0]             wr_mask,
  input  logic [PW-1:0]             rd_idx,
  output logic [AW-1:0]             rd_addr,
  output logic [DW-1:0]             rd_data,
  output logic [MW-1:0]             rd_mask,
  output logic [DEPTH-1:0][AW-1:0]  e_addr,
  output logic [DEPTH-1:0][DW-1:0]  e_data,
  output logic [DEPTH-1:0][MW-1:0]  e_mask
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == PW'(g));
    always_ff @(posedge clk) begin
      if (sel) begin
        e_addr[g] <= wr_addr;
        e_data[g] <= wr_data;
        e_mask[g] <= wr_mask;
      end
    end
  end

  always_comb begin
    rd_addr = e_addr[rd_idx];
    rd_data = e_data[rd_idx];
    rd_mask = e_mask[rd_idx];
  end
endmodule

// File: rtl/tsq_fwd.sv
`timescale 1ns/1ps
// Load lookup: youngest overlapping entry, coverage test, fence hold.
module tsq_fwd #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int MW = DW / 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic                     ld_valid,
  input  logic [AW-1:0]            ld_addr,
  input  logic [MW-1:0]            ld_mask,
  input  logic                     fence_hold,
  input  logic [PW-1:0]            head,
  input  logic [CW-1:0]            occ,
  input  logic [DEPTH-1:0][AW-1:0] e_addr,
  input  logic [DEPTH-1:0][DW-1:0] e_data,
  input  logic [DEPTH-1:0][MW-1:0] e_mask,
  output logic [1:0]               ld_res,
  output logic [DW-1:0]            ld_data
);
  import tsq_pkg::*;

  logic          hit;
  logic [PW-1:0] sel;
  ld_res_e       res;

  // Scan from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CW'(k) < occ)
          && (e_addr[head + PW'(k)] == ld_addr)
          && ((e_mask[head + PW'(k)] & ld_mask) != '0)) begin
        hit = 1'b1;
        sel = head + PW'(k);
      end
    end
  end

  always_comb begin
    if (!ld_valid)                             res = LD_CACHE;
    else if (fence_hold)                       res = LD_STALL;
    else if (hit && ((ld_mask & ~e_mask[sel]) != '0)) res = LD_STALL;
    else if (hit)                              res = LD_FWD;
    else                                       res = LD_CACHE;
    ld_res  = res;
    ld_data = hit ? e_data[sel] : '0;
  end
endmodule

// File: rtl/tso_stq.sv
`timescale 1ns/1ps
module tso_stq #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int MW = DW / 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [MW-1:0] st_mask,
  output logic          st_full,
  input  logic          rt_valid,
  input  logic          flush,
  input  logic          fence_req,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [MW-1:0] ld_mask,
  output logic [1:0]    ld_res,
  output logic [DW-1:0] ld_data,
  output logic          c_valid,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  output logic [MW-1:0] c_mask,
  input  logic          c_ready
);
  logic                     push;
  logic [PW-1:0]            head, tail;
  logic [CW-1:0]            occ, ret_cnt;
  logic                     fence_hold;
  logic [DEPTH-1:0][AW-1:0] e_addr;
  logic [DEPTH-1:0][DW-1:0] e_data;
  logic [DEPTH-1:0][MW-1:0] e_mask;

  assign fence_hold = fence_req && (occ != '0);

  tsq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .rt_valid(rt_valid),
    .flush(flush), .c_ready(c_ready), .push(push), .st_full(st_full),
    .c_valid(c_valid), .head(head), .tail(tail), .occ(occ), .ret_cnt(ret_cnt)
  );

  tsq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .wr_en(push), .wr_idx(tail), .wr_addr(st_addr),
    .wr_data(st_data), .wr_mask(st_mask), .rd_idx(head),
    .rd_addr(c_addr), .rd_data(c_data), .rd_mask(c_mask),
    .e_addr(e_addr), .e_data(e_data), .e_mask(e_mask)
  );

  tsq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mask(ld_mask),
    .fence_hold(fence_hold), .head(head), .occ(occ),
    .e_addr(e_addr), .e_data(e_data), .e_mask(e_mask),
    .ld_res(ld_res), .ld_data(ld_data)
  );
endmodule

// File: rtl/tsq_chk.sv
`timescale 1ns/1ps
module tsq_chk #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int MW = DW / 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_full,
  input logic          rt_valid,
  input logic          flush,
  input logic          fence_req,
  input logic          ld_valid,
  input logic [1:0]    ld_res,
  input logic          c_valid,
  input logic          c_ready,
  input logic [AW-1:0] c_addr,
  input logic [DW-1:0] c_data,
  input logic [MW-1:0] c_mask,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] ret_cnt
);
  a_r1_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    st_full && st_valid |=> occ <= $past(occ));

  a_r2_retired_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
    ret_cnt <= occ);

  a_r3_commit_after_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_valid) |-> $past(rt_valid));

  a_r4_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_ready |=> c_valid && $stable(c_addr) && $stable(c_data) && $stable(c_mask));

  a_r8_fence_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && ld_valid && (occ != '0) |-> ld_res == 2'd2);

  a_r9_flush_leaves_retired: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ret_cnt == occ);
endmodule

bind tso_stq tsq_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_full(st_full),
  .rt_valid(rt_valid), .flush(flush), .fence_req(fence_req),
  .ld_valid(ld_valid), .ld_res(ld_res), .c_valid(c_valid), .c_ready(c_ready),
  .c_addr(c_addr), .c_data(c_data), .c_mask(c_mask),
  .occ(occ), .ret_cnt(ret_cnt)
);

// File: tb/sim_tso_stq.sv
`timescale 1ns/1ps
module sim_tso_stq;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int MW = DW / 8;

  logic          clk, rst_n;
  logic          st_valid, rt_valid, flush, fence_req, ld_valid, c_ready;
  logic [AW-1:0] st_addr, ld_addr;
  logic [DW-1:0] st_data;
  logic [MW-1:0] st_mask, ld_mask;
  logic          st_full, c_valid;
  logic [1:0]    ld_res;
  logic [DW-1:0] ld_data, c_data;
  logic [AW-1:0] c_addr;
  logic [MW-1:0] c_mask;

  int total = 0;
  int fails = 0;
  bit done = 0;

  tso_stq #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_mask(st_mask), .st_full(st_full),
    .rt_valid(rt_valid), .flush(flush), .fence_req(fence_req),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_mask(ld_mask),
    .ld_res(ld_res), .ld_data(ld_data), .c_valid(c_valid),
    .c_addr(c_addr), .c_data(c_data), .c_mask(c_mask), .c_ready(c_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [MW-1:0] m);
    st_valid = 1'b1; st_addr = a; st_data = d; st_mask = m;
    cyc();
    st_valid = 1'b0;
  endtask

  task automatic probe(input string req, input logic [AW-1:0] a, input logic [MW-1:0] m,
                       input logic [1:0] er, input logic [DW-1:0] ed, input bit cd);
    ld_valid = 1'b1; ld_addr = a; ld_mask = m;
    #1;
    check(req, 32'(ld_res), 32'(er));
    if (cd) check(req, ld_data, ed);
    ld_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    st_valid = 0; rt_valid = 0; flush = 0; fence_req = 0; ld_valid = 0; c_ready = 0;
    st_addr = '0; st_data = '0; st_mask = '0; ld_addr = '0; ld_mask = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // Reset state
    #1;
    check("R1 reset not full", 32'(st_full), 0);
    check("R3 reset no commit", 32'(c_valid), 0);
    probe("R6 reset load to cache", 8'h10, 4'hF, 2'd0, '0, 0);

    // Fill the queue
    push(8'h10, 32'hAAAA0001, 4'hF);
    push(8'h20, 32'hBBBB0002, 4'hF);
    push(8'h10, 32'hCCCC0003, 4'hF);
    push(8'h30, 32'hDDDD0004, 4'h3);
    #1;
    check("R1 full at depth", 32'(st_full), 1);
    push(8'h50, 32'h55555555, 4'hF);   // offered while full: dropped

    c_ready = 1'b1;
    #1;
    check("R3 no commit before retire", 32'(c_valid), 0);
    cyc();
    c_ready = 1'b0;

    probe("R5 youngest match forwards", 8'h10, 4'hF, 2'd1, 32'hCCCC0003, 1);
    probe("R5 single match forwards", 8'h20, 4'hF, 2'd1, 32'hBBBB0002, 1);
    probe("R6 other address goes to cache", 8'h40, 4'hF, 2'd0, '0, 0);
    probe("R1 full-time store not queued", 8'h50, 4'hF, 2'd0, '0, 0);
    probe("R7 partial cover stalls", 8'h30, 4'hF, 2'd2, '0, 0);
    probe("R5 covered subset forwards", 8'h30, 4'h1, 2'd1, 32'hDDDD0004, 1);

    // Retire two entries, hold the cache port
    rt_valid = 1'b1; cyc(); cyc(); rt_valid = 1'b0;
    #1;
    check("R3 head valid after retire", 32'(c_valid), 1);
    check("R3 head address", 32'(c_addr), 32'h10);
    check("R3 head data", c_data, 32'hAAAA0001);
    cyc();
    #1;
    check("R4 held without ready", 32'(c_addr), 32'h10);

    // Flush removes the two unretired entries
    flush = 1'b1; cyc(); flush = 1'b0;
    #1;
    check("R9 space after flush", 32'(st_full), 0);
    probe("R9 retired entry survives", 8'h10, 4'hF, 2'd1, 32'hAAAA0001, 1);
    probe("R9 unretired entry removed", 8'h30, 4'h1, 2'd0, '0, 0);

    // Full fence holds loads until empty
    fence_req = 1'b1;
    probe("R8 fence stalls unrelated load", 8'h40, 4'hF, 2'd2, '0, 0);
    c_ready = 1'b1;
    #1;
    check("R3 first commit oldest", 32'(c_addr), 32'h10);
    cyc();
    #1;
    check("R3 second commit address", 32'(c_addr), 32'h20);
    check("R3 second commit data", c_data, 32'hBBBB0002);
    cyc();
    #1;
    check("R4 queue drained", 32'(c_valid), 0);
    probe("R8 fence released when empty", 8'h40, 4'hF, 2'd0, '0, 0);
    fence_req = 1'b0;
    c_ready = 1'b0;

    // Retire with nothing unretired is ignored
    rt_valid = 1'b1; cyc(); rt_valid = 1'b0;
    push(8'h60, 32'h66666666, 4'hF);
    c_ready = 1'b1;
    #1;
    check("R2 stray retire ignored", 32'(c_valid), 0);
    cyc();
    c_ready = 1'b0;

    // Store offered together with a flush
    st_valid = 1'b1; st_addr = 8'h70; st_data = 32'h77777777; st_mask = 4'hF;
    flush = 1'b1; cyc(); flush = 1'b0; st_valid = 1'b0;
    probe("R1 store during flush dropped", 8'h70, 4'hF, 2'd0, '0, 0);
    probe("R9 unretired 0x60 flushed", 8'h60, 4'hF, 2'd0, '0, 0);

    // Byte overlap rules
    push(8'h90, 32'h11112222, 4'h3);
    push(8'h90, 32'h33334444, 4'hC);
    probe("R5 older non-overlapped match", 8'h90, 4'h3, 2'd1, 32'h11112222, 1);
    probe("R5 younger overlap forwards", 8'h90, 4'h4, 2'd1, 32'h33334444, 1);
    probe("R7 youngest overlap not covering", 8'h90, 4'h6, 2'd2, '0, 0);
    rt_valid = 1'b1; cyc(); cyc(); rt_valid = 1'b0;
    c_ready = 1'b1; cyc(); cyc(); c_ready = 1'b0;
    #1;
    check("R3 overlap entries drained", 32'(c_valid), 0);

    // Streaming sweep with wrap-around and irregular ready
    begin
      int pushed = 0;
      int commits = 0;
      for (int t = 0; t < 200 && commits < 12; t++) begin
        st_valid = (pushed < 12);
        st_addr  = AW'(8'h80 + pushed);
        st_data  = 32'(pushed) * 32'h01010101;
        st_mask  = 4'hF;
        rt_valid = 1'b1;
        c_ready  = (t % 3) != 0;
        #1;
        if (c_valid && c_ready) begin
          check("R3 sweep commit order", 32'(c_addr), 32'h80 + 32'(commits));
          check("R3 sweep commit data", c_data, 32'(commits) * 32'h01010101);
          commits++;
        end
        if (st_valid && !st_full) pushed++;
        cyc();
      end
      st_valid = 1'b0; rt_valid = 1'b0; c_ready = 1'b0;
      check("R3 sweep all committed", 32'(commits), 12);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule